// File: doc/BRIEF.md
# Floppy Drive Select with Motor Timeout and CPU Wait

This block is the write-only control register that sits between the processor and a floppy subsystem. One port write sets the recording density, the write precompensation enable, the head side and the drive selection. The same write starts the selected drive's spindle motor, and it can also ask the processor to be held in a wait state until the disk controller needs service.

The motor runs on a down-counter that advances on a slow real-time tick. Every write that names a drive reloads that counter. When the counter runs out, the motor stops, the drive is deselected and a one-cycle timeout event is produced. Interrupt logic can record this event as a motor-timeout cause.

The wait request is raised only when the controller has neither a data request nor an interrupt request pending at the time of the write. A rising edge on either request line releases the processor.

Top module: `fdsel_ctrl`

## Requirements
- R1: After reset, drive_sel is all zero, side_sel, precomp_en, motor_on, wait_req and motor_timeout are 0, and density_n is 1.
- R2: On the cycle after a write, density_n equals the inverse of data bit 7, precomp_en equals bit 5 and side_sel equals bit 4.
- R3: On the cycle after a write, drive_sel is one-hot on the highest-numbered set bit among data bits 3..0, and it is all zero when none of those bits is set.
- R4: A write with any of bits 3..0 set turns motor_on on in the next cycle and loads the timeout counter with TIMEOUT_TICKS.
- R5: Each tick lowers a nonzero counter by one. With TIMEOUT_TICKS loaded, motor_on stays 1 through TIMEOUT_TICKS-1 ticks. A tick while the counter is zero changes no output.
- R6: The tick that brings the counter to zero causes, in the next cycle, motor_on to go 0, drive_sel to clear and motor_timeout to pulse high for exactly one cycle.
- R7: A write with bit 6 set raises wait_req in the next cycle only if drq and intrq are both low at the write. Otherwise wait_req stays 0.
- R8: A write with bit 6 clear drives wait_req to 0 in the next cycle.
- R9: A rising edge on drq or on intrq drives wait_req to 0 in the next cycle. Both lines count as low at reset.
- R10: A drive-selecting write in the same cycle as a tick takes priority. The counter restarts at TIMEOUT_TICKS, and no decrement is applied that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Written value (bit 7 density, bit 6 wait, bit 5 precomp, bit 4 side, bits 3..0 drives) |
| drq | input | 1 | Disk controller data request |
| intrq | input | 1 | Disk controller interrupt request |
| tick | input | 1 | Real-time tick, one cycle wide |
| drive_sel | output | NUM_DRIVES | One-hot drive select |
| side_sel | output | 1 | Head side |
| density_n | output | 1 | Density to controller, low for MFM |
| precomp_en | output | 1 | Write precompensation enable |
| motor_on | output | 1 | Spindle motor enable |
| wait_req | output | 1 | Processor wait request |
| motor_timeout | output | 1 | One-cycle pulse when the motor timer expires |

## Verification
The bench builds the block with NUM_DRIVES = 4 and TIMEOUT_TICKS = 5. With this short timeout, a full countdown, its expiry, a reload in mid-countdown and a reload on the same cycle as a tick all fit into a few dozen cycles. Running all four drive bits exercises every position of the priority pick. A long random phase mixes writes, ticks and request edges so that timeouts collide with writes and wait requests collide with request edges. That phase runs many times more often than it could with a counter reload value in the thousands.

// File: rtl/fdsel_pkg.sv
package fdsel_pkg;

   // Layout of the written control byte; bit positions are decoded by hardware
   typedef struct packed {
      logic       mfm;       // bit 7
      logic       hold_cpu;  // bit 6
      logic       precomp;   // bit 5
      logic       side;      // bit 4
      logic [3:0] drives;    // bits 3..0
   } fdsel_ctl_t;

   localparam int unsigned MAX_DRIVES = 4;

endpackage

// File: rtl/fdsel_prio.sv
module fdsel_prio #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);

   if (N < 1) begin : g_bad_n
      $error("fdsel_prio: N must be at least 1");
   end

   // Highest-numbered request wins
   for (genvar i = 0; i < N; i++) begin : g_bit
      if (i == N - 1) begin : g_top
         assign gnt[i] = req[i];
      end else begin : g_low
         assign gnt[i] = req[i] & ~(|req[N-1:i+1]);
      end
   end

endmodule

// File: rtl/fdsel_motor_timer.sv
module fdsel_motor_timer #(
   parameter int unsigned TICKS = 1600
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic tick,
   output logic motor_on,
   output logic expire,
   output logic expire_evt
);

   localparam int unsigned CNT_W = (TICKS < 2) ? 1 : $clog2(TICKS + 1);
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TICKS);
   localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

   if (TICKS < 1) begin : g_bad_ticks
      $error("fdsel_motor_timer: TICKS must be at least 1");
   end

   logic [CNT_W-1:0] cnt;

   assign motor_on = (cnt != '0);
   assign expire   = tick && !load && (cnt == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         expire_evt <= 1'b0;
      end else begin
         expire_evt <= expire;
         if (load)
            cnt <= RELOAD;
         else if (tick && cnt != '0)
            cnt <= cnt - ONE;
      end
   end

endmodule

// File: rtl/fdsel_wait.sv
module fdsel_wait (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic hold_bit,
   input  logic drq,
   input  logic intrq,
   output logic wait_req
);

   logic drq_q, intrq_q;
   logic released;

   assign released = (drq && !drq_q) || (intrq && !intrq_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drq_q    <= 1'b0;
         intrq_q  <= 1'b0;
         wait_req <= 1'b0;
      end else begin
         drq_q   <= drq;
         intrq_q <= intrq;
         if (released)
            wait_req <= 1'b0;
         else if (wr_en) begin
            if (!hold_bit)
               wait_req <= 1'b0;
            else if (!drq && !intrq)
               wait_req <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/fdsel_ctrl.sv
module fdsel_ctrl #(
   parameter int unsigned NUM_DRIVES    = 4,
   parameter int unsigned TIMEOUT_TICKS = 1600
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [7:0]            wr_data,
   input  logic                  drq,
   input  logic                  intrq,
   input  logic                  tick,
   output logic [NUM_DRIVES-1:0] drive_sel,
   output logic                  side_sel,
   output logic                  density_n,
   output logic                  precomp_en,
   output logic                  motor_on,
   output logic                  wait_req,
   output logic                  motor_timeout
);
   import fdsel_pkg::*;

   if (NUM_DRIVES < 1 || NUM_DRIVES > MAX_DRIVES) begin : g_bad_drives
      $error("fdsel_ctrl: NUM_DRIVES must be 1..4");
   end

   fdsel_ctl_t            ctl;
   logic [NUM_DRIVES-1:0] sel_req, sel_gnt;
   logic                  any_sel, expire;

   assign ctl     = fdsel_ctl_t'(wr_data);
   assign sel_req = ctl.drives[NUM_DRIVES-1:0];
   assign any_sel = |sel_req;

   fdsel_prio #(.N(NUM_DRIVES)) u_prio (
      .req (sel_req),
      .gnt (sel_gnt)
   );

   fdsel_motor_timer #(.TICKS(TIMEOUT_TICKS)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (wr_en && any_sel),
      .tick       (tick),
      .motor_on   (motor_on),
      .expire     (expire),
      .expire_evt (motor_timeout)
   );

   fdsel_wait u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .hold_bit (ctl.hold_cpu),
      .drq      (drq),
      .intrq    (intrq),
      .wait_req (wait_req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drive_sel  <= '0;
         side_sel   <= 1'b0;
         density_n  <= 1'b1;
         precomp_en <= 1'b0;
      end else if (wr_en) begin
         drive_sel  <= sel_gnt;
         side_sel   <= ctl.side;
         density_n  <= ~ctl.mfm;
         precomp_en <= ctl.precomp;
      end else if (expire) begin
         drive_sel  <= '0;
      end
   end

endmodule

// File: rtl/fdsel_ctrl_chk.sv
module fdsel_ctrl_chk #(
   parameter int unsigned NUM_DRIVES = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  wr_en,
   input logic [7:0]            wr_data,
   input logic                  drq,
   input logic                  intrq,
   input logic [NUM_DRIVES-1:0] drive_sel,
   input logic                  density_n,
   input logic                  motor_on,
   input logic                  wait_req,
   input logic                  motor_timeout
);

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(drive_sel)); // R3

   AST_DENSITY_INV: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> density_n == !$past(wr_data[7])); // R2

   AST_MOTOR_START: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && |wr_data[NUM_DRIVES-1:0]) |=> motor_on); // R4

   AST_EXPIRE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      motor_timeout |-> (!motor_on && drive_sel == '0)); // R6

   AST_EXPIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      motor_timeout |=> !motor_timeout); // R6

   AST_WAIT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (drq || intrq) && !wait_req) |=> !wait_req); // R7

   AST_WAIT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[6]) |=> !wait_req); // R8

   AST_WAIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(drq) || $rose(intrq)) |=> !wait_req); // R9

endmodule

bind fdsel_ctrl fdsel_ctrl_chk #(.NUM_DRIVES(NUM_DRIVES)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_en         (wr_en),
   .wr_data       (wr_data),
   .drq           (drq),
   .intrq         (intrq),
   .drive_sel     (drive_sel),
   .density_n     (density_n),
   .motor_on      (motor_on),
   .wait_req      (wait_req),
   .motor_timeout (motor_timeout)
);

// File: tb/sim_fdsel_ctrl.sv
module sim_fdsel_ctrl;
   localparam int ND = 4;
   localparam int TO = 5;

   logic          clk = 0;
   logic          rst_n = 0;
   logic          wr_en = 0;
   logic [7:0]    wr_data = 0;
   logic          drq = 0, intrq = 0, tick = 0;
   logic [ND-1:0] drive_sel;
   logic          side_sel, density_n, precomp_en, motor_on, wait_req, motor_timeout;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   fdsel_ctrl #(.NUM_DRIVES(ND), .TIMEOUT_TICKS(TO)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .drq(drq), .intrq(intrq), .tick(tick),
      .drive_sel(drive_sel), .side_sel(side_sel), .density_n(density_n),
      .precomp_en(precomp_en), .motor_on(motor_on), .wait_req(wait_req),
      .motor_timeout(motor_timeout));

   // Behavioural reference
   int m_cnt, m_sel, m_side, m_dens_n, m_pre, m_wait, m_evt, m_drq_q, m_int_q;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_sel = 0; m_side = 0; m_dens_n = 1; m_pre = 0;
         m_wait = 0; m_evt = 0; m_drq_q = 0; m_int_q = 0;
      end else begin
         bit rise;
         rise = (drq && m_drq_q == 0) || (intrq && m_int_q == 0);
         m_evt = 0;
         if (wr_en) begin
            int hi;
            hi = -1;
            for (int i = 0; i < ND; i++) if (wr_data[i]) hi = i;
            m_sel = (hi < 0) ? 0 : (1 << hi);
            m_side = wr_data[4]; m_pre = wr_data[5]; m_dens_n = !wr_data[7];
            if (hi >= 0) m_cnt = TO;
            else if (tick && m_cnt > 0) begin
               m_cnt--;
               if (m_cnt == 0) m_evt = 1;
            end
            if (!wr_data[6]) m_wait = 0;
            else if (!drq && !intrq) m_wait = 1;
         end else if (tick && m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin m_sel = 0; m_evt = 1; end
         end
         if (rise) m_wait = 0;
         m_drq_q = drq; m_int_q = intrq;
      end
   end

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Cycle-by-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R3 drive_sel", drive_sel, m_sel);
         check("R2 side_sel", side_sel, m_side);
         check("R2 density_n", density_n, m_dens_n);
         check("R2 precomp_en", precomp_en, m_pre);
         check("R4 motor_on", motor_on, m_cnt > 0);
         check("R7 wait_req", wait_req, m_wait);
         check("R6 motor_timeout", motor_timeout, m_evt);
      end
   end

   task automatic step(bit w, logic [7:0] d, bit t);
      @(negedge clk); #1;
      wr_en = w; wr_data = d; tick = t;
      @(negedge clk); #1;
      wr_en = 0; tick = 0;
   endtask

   task automatic lines(bit d, bit i);
      @(negedge clk); #1;
      drq = d; intrq = i;
      @(negedge clk); #1;
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      done = 1;
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1;
      @(negedge clk); #1;
      // R1 reset state
      check("R1 sel", drive_sel, 0);
      check("R1 dens", density_n, 1);
      check("R1 motor", motor_on, 0);
      check("R1 wait", wait_req, 0);
      check("R1 evt", motor_timeout, 0);

      step(1, 8'h81, 0);                 // MFM, drive 0
      check("R2 mfm", density_n, 0);
      check("R3 drv0", drive_sel, 4'b0001);
      check("R4 motor", motor_on, 1);
      step(1, 8'h3F, 0);                 // all drives, side, precomp
      check("R3 highest", drive_sel, 4'b1000);
      check("R2 side", side_sel, 1);
      check("R2 pre", precomp_en, 1);
      step(1, 8'h50, 0);                 // wait, no drive
      check("R3 none", drive_sel, 0);
      check("R7 set", wait_req, 1);
      lines(1, 0);
      check("R9 drq", wait_req, 0);
      step(1, 8'h40, 0);                 // drq high: blocked
      check("R7 blocked", wait_req, 0);
      lines(0, 0);
      step(1, 8'h40, 0);
      check("R7 set2", wait_req, 1);
      step(1, 8'h00, 0);
      check("R8 clear", wait_req, 0);
      step(1, 8'h40, 0);
      lines(0, 1);
      check("R9 intrq", wait_req, 0);
      lines(0, 0);

      // Countdown and expiry
      step(1, 8'h02, 0);
      for (int k = 0; k < TO - 1; k++) step(0, 0, 1);
      check("R5 still on", motor_on, 1);
      @(negedge clk); #1 tick = 1;
      @(negedge clk); #1 tick = 0;
      check("R6 off", motor_on, 0);
      check("R6 evt", motor_timeout, 1);
      check("R6 sel", drive_sel, 0);
      @(negedge clk); #1;
      check("R6 pulse", motor_timeout, 0);
      step(0, 0, 1);
      check("R5 idle", motor_on, 0);

      // Reload colliding with tick
      step(1, 8'h04, 0);
      step(0, 0, 1); step(0, 0, 1); step(0, 0, 1);
      step(1, 8'h04, 1);
      for (int k = 0; k < TO - 1; k++) step(0, 0, 1);
      check("R10 reload", motor_on, 1);
      step(0, 0, 1);
      check("R10 expire", motor_on, 0);

      // Random traffic
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk); #1;
         wr_en   = ($urandom % 8) == 0;
         wr_data = 8'($urandom);
         tick    = ($urandom % 3) == 0;
         if (($urandom % 6) == 0) drq = ~drq;
         if (($urandom % 7) == 0) intrq = ~intrq;
      end
      @(negedge clk); #1 wr_en = 0; tick = 0;
      @(negedge clk);
      done = 1;
      summary();
   end
endmodule